// File: doc/BRIEF.md
# Four-Channel Compare Alarm Controller

This block provides four independent one-shot alarms for a system timebase. Each alarm holds a 32-bit target. Writing the target both loads it and arms the alarm. While an alarm is armed, the block compares its target with the low 32 bits of the free-running timebase, which arrives as an input, on every clock cycle. When the two values are equal, the alarm raises its raw interrupt and disarms itself.

Software reaches the block over an APB slave port. It can read the targets and the armed status, cancel pending alarms, and manage the interrupts. For each alarm there is a raw bit that is cleared by writing 1, an enable bit and a force bit. The masked status of each alarm drives its own interrupt line. The bus interface completes every transfer without wait states. Reads return data during the access phase.

Top module: `cau_top`

## Requirements
- R1: After reset, every target, armed bit, raw bit, enable bit and force bit is 0, and all interrupt lines are low.
- R2: A write to the target of alarm i (offset 0x10 + 4*i) stores the write data. The target reads back this value from the next cycle onward. The write also sets armed bit i, which is bit i of the status word at offset 0x20.
- R3: An armed alarm i whose target equals the low timebase word at a clock edge sets raw bit i (bit i at offset 0x3C) and clears its own armed bit on that edge.
- R4: A match between the target and the timebase has no effect on an alarm that is not armed: its raw bit does not change.
- R5: Writing to offset 0x20 disarms each alarm whose data bit is 1. The disarmed alarm does not fire. Alarms whose data bit is 0 keep their state.
- R6: Writing to offset 0x3C clears each raw bit whose data bit is 1. If an alarm fires on the same edge as the clear of its own raw bit, that bit stays set.
- R7: The enable word (offset 0x40) and the force word (offset 0x44) are read/write and 4 bits wide. Data bits above bit 3 are ignored.
- R8: The status word at offset 0x48 is read-only and equals (raw AND enable) OR force. Interrupt line i equals status bit i.
- R9: If a target write and a match on the same alarm occur on the same edge, the alarm does not fire. It ends armed with the new target.
- R10: The compare uses the timebase value present on each edge. If the timebase holds still at a value that differs from the target, the alarm never fires. If it holds still at the target value, the alarm fires exactly once.
- R11: Addresses outside the map read as 0, and writes to them change no state. A write to the status word (offset 0x48) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_lo_i | input | 32 | Low word of the shared timebase |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | APB ready, always high |
| irq_o | output | 4 | Per-alarm interrupt lines |

## Verification
The bench builds the block with its default parameters: four alarms, 32-bit data and an 8-bit address. With these values every channel, the full register map and the data bits above the 4-bit interrupt fields are all exercised. The random phase holds or steps the timebase slowly, at times close to the 32-bit wrap point. It draws targets a few counts away from the current time, so equality, self-disarm and the races of a write or clear against a firing occur often. Directed cases line up the edges exactly for the R6 and R9 races.

// File: rtl/cau_pkg.sv
package cau_pkg;
  localparam int OFF_TGT_BASE = 'h10;
  localparam int OFF_ARMED    = 'h20;
  localparam int OFF_RAW      = 'h3C;
  localparam int OFF_EN       = 'h40;
  localparam int OFF_FRC      = 'h44;
  localparam int OFF_STAT     = 'h48;
endpackage

// File: rtl/cau_decode.sv
module cau_decode
  import cau_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                       psel,
  input  logic                       penable,
  input  logic                       pwrite,
  input  logic [ADDR_W-1:0]          paddr,
  input  logic [DATA_W-1:0]          pwdata,
  input  logic [N-1:0][DATA_W-1:0]   tgt_i,
  input  logic [N-1:0]               armed_i,
  input  logic [N-1:0]               raw_i,
  input  logic [N-1:0]               en_i,
  input  logic [N-1:0]               frc_i,
  input  logic [N-1:0]               stat_i,
  output logic [N-1:0]               tgt_wr_o,
  output logic [N-1:0]               disarm_o,
  output logic [N-1:0]               raw_clr_o,
  output logic                       en_wr_o,
  output logic                       frc_wr_o,
  output logic [DATA_W-1:0]          prdata
);
  localparam logic [ADDR_W-1:0] A_ARMED = ADDR_W'(OFF_ARMED);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFF_RAW);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(OFF_EN);
  localparam logic [ADDR_W-1:0] A_FRC   = ADDR_W'(OFF_FRC);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);

  logic wr;
  assign wr = psel && penable && pwrite;

  for (genvar i = 0; i < N; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_TGT = ADDR_W'(OFF_TGT_BASE + 4 * i);
    assign tgt_wr_o[i]  = wr && (paddr == A_TGT);
    assign disarm_o[i]  = wr && (paddr == A_ARMED) && pwdata[i];
    assign raw_clr_o[i] = wr && (paddr == A_RAW) && pwdata[i];
  end

  assign en_wr_o  = wr && (paddr == A_EN);
  assign frc_wr_o = wr && (paddr == A_FRC);

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      for (int i = 0; i < N; i++) begin
        if (paddr == ADDR_W'(OFF_TGT_BASE + 4 * i)) prdata = tgt_i[i];
      end
      if (paddr == A_ARMED) prdata = DATA_W'(armed_i);
      if (paddr == A_RAW)   prdata = DATA_W'(raw_i);
      if (paddr == A_EN)    prdata = DATA_W'(en_i);
      if (paddr == A_FRC)   prdata = DATA_W'(frc_i);
      if (paddr == A_STAT)  prdata = DATA_W'(stat_i);
    end
  end
endmodule

// File: rtl/cau_alarm_chan.sv
module cau_alarm_chan #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tgt_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              disarm_i,
  input  logic [DATA_W-1:0] time_lo_i,
  output logic [DATA_W-1:0] target_o,
  output logic              armed_o,
  output logic              fire_o
);
  logic [DATA_W-1:0] target_q;
  logic              armed_q;

  // A target write on the same edge takes precedence over the match.
  assign fire_o   = armed_q && (target_q == time_lo_i) && !tgt_wr_i;
  assign target_o = target_q;
  assign armed_o  = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      armed_q  <= 1'b0;
    end else begin
      if (tgt_wr_i) target_q <= wdata_i;
      if (tgt_wr_i)                 armed_q <= 1'b1;
      else if (fire_o || disarm_i)  armed_q <= 1'b0;
    end
  end

  AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_wr_i |=> (armed_q && (target_q == $past(wdata_i)))); // R2
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_wr_i |=> $stable(target_q)); // R2
  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !armed_q); // R3
  AST_SW_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (disarm_i && !tgt_wr_i) |=> !armed_q); // R5
endmodule

// File: rtl/cau_irq_front.sv
module cau_irq_front #(
  parameter int N      = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      fire_i,
  input  logic [N-1:0]      raw_clr_i,
  input  logic              en_wr_i,
  input  logic              frc_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N-1:0]      raw_o,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      frc_o,
  output logic [N-1:0]      stat_o
);
  logic [N-1:0] raw_q, en_q, frc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
      frc_q <= '0;
    end else begin
      // A firing on the same edge as its clear leaves the bit set.
      raw_q <= (raw_q & ~raw_clr_i) | fire_i;
      if (en_wr_i)  en_q  <= wdata_i[N-1:0];
      if (frc_wr_i) frc_q <= wdata_i[N-1:0];
    end
  end

  assign raw_o  = raw_q;
  assign en_o   = en_q;
  assign frc_o  = frc_q;
  assign stat_o = (raw_q & en_q) | frc_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_FIRE_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i[i] |=> raw_q[i]); // R6
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_clr_i[i] && !fire_i[i]) |=> !raw_q[i]); // R6
    AST_RAW_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_q[i]) |-> $past(fire_i[i])); // R4
  end
endmodule

// File: rtl/cau_top.sv
module cau_top #(
  parameter int N      = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] time_lo_i,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic [N-1:0]      irq_o
);
  logic [N-1:0][DATA_W-1:0] tgt;
  logic [N-1:0] armed, fire, tgt_wr, disarm, raw_clr;
  logic [N-1:0] raw, en, frc, stat;
  logic         en_wr, frc_wr;

  cau_decode #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .tgt_i(tgt), .armed_i(armed), .raw_i(raw),
    .en_i(en), .frc_i(frc), .stat_i(stat), .tgt_wr_o(tgt_wr),
    .disarm_o(disarm), .raw_clr_o(raw_clr), .en_wr_o(en_wr),
    .frc_wr_o(frc_wr), .prdata(prdata)
  );

  for (genvar i = 0; i < N; i++) begin : g_alarm
    cau_alarm_chan #(.DATA_W(DATA_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tgt_wr_i(tgt_wr[i]), .wdata_i(pwdata),
      .disarm_i(disarm[i]), .time_lo_i(time_lo_i), .target_o(tgt[i]),
      .armed_o(armed[i]), .fire_o(fire[i])
    );
  end

  cau_irq_front #(.N(N), .DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .raw_clr_i(raw_clr),
    .en_wr_i(en_wr), .frc_wr_i(frc_wr), .wdata_i(pwdata),
    .raw_o(raw), .en_o(en), .frc_o(frc), .stat_o(stat)
  );

  assign pready = 1'b1;
  assign irq_o  = stat;

  AST_FORCE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frc_wr && pwdata[0]) |-> irq_o[0]); // R8
endmodule

// File: tb/cau_top_tb_top.sv
module cau_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] time_lo = '0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;
  logic          pready;
  logic [N-1:0]  irq_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cau_top #(.N(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .time_lo_i(time_lo), .psel(psel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .pready(pready), .irq_o(irq_o)
  );

  // Reference model built from the requirements.
  logic [DW-1:0] m_tgt [N];
  logic [N-1:0]  m_arm, m_raw, m_en, m_frc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_tgt[i] <= '0;
      m_arm <= '0; m_raw <= '0; m_en <= '0; m_frc <= '0;
    end else begin : mdl
      logic wr;
      logic [N-1:0] f, na;
      wr = psel && penable && pwrite;
      na = m_arm;
      for (int i = 0; i < N; i++) begin
        logic tw;
        tw = wr && (paddr == AW'(8'h10 + 4*i));
        f[i] = m_arm[i] && (m_tgt[i] == time_lo) && !tw;
        if (tw) begin
          na[i] = 1'b1;
          m_tgt[i] <= pwdata;
        end else if (f[i] || (wr && paddr == 8'h20 && pwdata[i])) na[i] = 1'b0;
      end
      m_arm <= na;
      m_raw <= (m_raw & ~((wr && paddr == 8'h3C) ? pwdata[N-1:0] : '0)) | f;
      if (wr && paddr == 8'h40) m_en  <= pwdata[N-1:0];
      if (wr && paddr == 8'h44) m_frc <= pwdata[N-1:0];
    end
  end

  function automatic logic [DW-1:0] model_read(logic [AW-1:0] a);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < N; i++) if (a == AW'(8'h10 + 4*i)) r = m_tgt[i];
    case (a)
      8'h20: r = DW'(m_arm);
      8'h3C: r = DW'(m_raw);
      8'h40: r = DW'(m_en);
      8'h44: r = DW'(m_frc);
      8'h48: r = DW'((m_raw & m_en) | m_frc);
      default: ;
    endcase
    return r;
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_time(logic [DW-1:0] t);
    @(negedge clk); time_lo = t;
  endtask

  // Write; the timebase changes to t_acc on the edge that performs the write.
  task automatic wr_t(logic [AW-1:0] a, logic [DW-1:0] d, logic [DW-1:0] t_acc);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1; time_lo = t_acc;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    wr_t(a, d, time_lo);
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #(CLK_PERIOD/4);
    d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [AW-1:0] a, logic [DW-1:0] exp);
    logic [DW-1:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic irq_chk(string tag, logic [N-1:0] exp);
    @(negedge clk); #(CLK_PERIOD/4);
    chk(tag, DW'(irq_o), DW'(exp));
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        report();
        $finish;
      end
    end
  end

  initial begin : stim
    logic [DW-1:0] d;
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    time_lo = 32'h1000;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    for (int i = 0; i < N; i++) rd_chk("R1 target", AW'(8'h10 + 4*i), 0);
    rd_chk("R1 armed", 8'h20, 0);
    rd_chk("R1 raw", 8'h3C, 0);
    rd_chk("R1 enable", 8'h40, 0);
    rd_chk("R1 force", 8'h44, 0);
    irq_chk("R1 irq", 4'h0);

    // R2 write arms and stores
    wr(8'h14, 32'h1005);
    rd_chk("R2 readback", 8'h14, 32'h1005);
    rd_chk("R2 armed", 8'h20, 32'h2);

    // R10 paused at a different value: no fire
    idle(20);
    rd_chk("R10 no fire while unequal", 8'h3C, 0);

    // R3 fire and self-disarm
    set_time(32'h1005);
    idle(2);
    rd_chk("R3 raw set", 8'h3C, 32'h2);
    rd_chk("R3 disarmed", 8'h20, 0);
    irq_chk("R8 masked irq", 4'h0);

    // R6 clear; R10 paused equal fires only once
    wr(8'h3C, 32'h2);
    idle(10);
    rd_chk("R6/R10 cleared and no refire", 8'h3C, 0);

    // R5 disarm; R4 match on unarmed alarm
    set_time(32'h2000);
    wr(8'h18, 32'h3000);
    wr(8'h20, 32'h4);
    rd_chk("R5 disarmed", 8'h20, 0);
    set_time(32'h3000);
    idle(3);
    rd_chk("R4 unarmed match ignored", 8'h3C, 0);
    rd_chk("R5 target kept", 8'h18, 32'h3000);

    // R5 zero bits keep state
    wr(8'h10, 32'h5000);
    wr(8'h1C, 32'h5001);
    wr(8'h20, 32'h8);
    rd_chk("R5 selective disarm", 8'h20, 32'h1);

    // R9 write races a match
    wr_t(8'h10, 32'h6000, 32'h5000);
    rd_chk("R9 no fire", 8'h3C, 0);
    rd_chk("R9 still armed", 8'h20, 32'h1);
    rd_chk("R9 new target", 8'h10, 32'h6000);

    // R6 clear races a fire
    set_time(32'h6000);
    idle(2);
    rd_chk("R3 alarm0 fired", 8'h3C, 32'h1);
    wr(8'h10, 32'h6100);
    wr_t(8'h3C, 32'h1, 32'h6100);
    rd_chk("R6 fire beats clear", 8'h3C, 32'h1);
    rd_chk("R6 alarm0 disarmed", 8'h20, 0);

    // R7 enable / force width; R8 status and lines
    wr(8'h40, 32'hFFFF_FFFF);
    rd_chk("R7 enable masked width", 8'h40, 32'hF);
    rd_chk("R8 status raw&en", 8'h48, 32'h1);
    irq_chk("R8 irq raw&en", 4'h1);
    wr(8'h44, 32'hFFFF_FFF8);
    rd_chk("R7 force masked width", 8'h44, 32'h8);
    rd_chk("R8 status with force", 8'h48, 32'h9);
    wr(8'h48, 32'h0);
    rd_chk("R11 status write ignored", 8'h48, 32'h9);
    wr(8'h40, 32'h0);
    irq_chk("R8 force only", 4'h8);
    wr(8'h44, 32'h0);
    irq_chk("R8 all low", 4'h0);

    // R11 unmapped
    rd_chk("R11 unmapped 0x00", 8'h00, 0);
    rd_chk("R11 unmapped 0x4C", 8'h4C, 0);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    rd_chk("R11 raw unchanged", 8'h3C, 32'h1);
    rd_chk("R11 armed unchanged", 8'h20, 0);
    rd_chk("R11 enable unchanged", 8'h40, 0);

    // Random phase against the model, near the 32-bit wrap point
    time_lo = 32'hFFFF_FFF0;
    for (int k = 0; k < 600; k++) begin
      int op;
      logic [DW-1:0] t_acc;
      op = $urandom_range(0, 9);
      t_acc = time_lo + DW'($urandom_range(0, 1));
      case (op)
        0, 1, 2: wr_t(AW'(8'h10 + 4*$urandom_range(0, N-1)),
                      time_lo + DW'($urandom_range(0, 5)), t_acc);
        3: wr_t(8'h20, DW'($urandom_range(0, 15)), t_acc);
        4: wr_t(8'h3C, DW'($urandom_range(0, 15)), t_acc);
        5: wr_t(8'h40, $urandom, t_acc);
        6: wr_t(8'h44, DW'($urandom_range(0, 15)) & DW'($urandom_range(0, 15)), t_acc);
        7: set_time(time_lo + DW'($urandom_range(0, 2)));
        default: begin
          logic [AW-1:0] a;
          logic [DW-1:0] exp;
          a = AW'(4 * $urandom_range(0, 19));
          @(negedge clk);
          psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
          @(negedge clk);
          penable = 1'b1;
          #(CLK_PERIOD/4);
          exp = model_read(a);
          case (a)
            8'h20: chk("R5 random armed", prdata, exp);
            8'h3C: chk("R3 random raw", prdata, exp);
            8'h48: chk("R8 random status", prdata, exp);
            default: chk("R2 random reg", prdata, exp);
          endcase
          chk("R8 random irq", DW'(irq_o), DW'((m_raw & m_en) | m_frc));
          @(negedge clk);
          psel = 1'b0; penable = 1'b0;
        end
      endcase
    end

    for (int a = 0; a < 20; a++) begin
      rd(AW'(4*a), d);
      chk("R11 final map sweep", d, model_read(AW'(4*a)));
    end

    done = 1'b1;
    report();
    $finish;
  end
endmodule